// File: doc/BRIEF.md
# Multipath Delay Searcher Correlator

This block finds the arrival delays of the strongest propagation paths in a received frame. Software or an upstream stage first writes a frame of real, signed samples into the block's sample store and writes one code chip per window position into its chip store. A start pulse then launches a sweep. At each candidate offset the block slides a fixed-length window over the stored frame and accumulates the samples weighted by the ±1 chips. Because each chip is ±1, every weighting step is an add or a subtract, and no multiplier is needed.

The absolute value of each window sum is the correlation magnitude for that offset. The block keeps a sorted list of the three largest magnitudes and their offsets across the whole sweep. When every offset has been processed, it raises a one-cycle done pulse. The three delay/magnitude pairs then go to three despreading fingers, which use them to align and weight the multipath copies.

Top module: `path_search_top`

## Requirements
- R1: After reset, done is low and all three delay outputs and all three magnitude outputs are zero.
- R2: For every offset o from 0 to BUF_DEPTH-WIN_LEN, the block forms C(o) = sum over k of chip(k)·sample(o+k) for k = 0..WIN_LEN-1. Samples are two's-complement signed, SAMPLE_W bits wide. A stored chip bit of 1 stands for +1 and a bit of 0 stands for -1.
- R3: The reported magnitude is |C(o)| as an unsigned value ACC_W = SAMPLE_W+clog2(WIN_LEN)+1 bits wide. It is exact even at full-scale negative sums, with no wrap.
- R4: Slot 0 holds the offset with the largest magnitude, slot 1 the next largest and slot 2 the third largest, so that magnitude 0 ≥ magnitude 1 ≥ magnitude 2.
- R5: When two offsets have equal magnitudes, the smaller offset ranks higher. For example, an all-zero frame reports delays 0, 1 and 2.
- R6: Done is high for exactly one cycle. It rises exactly (BUF_DEPTH-WIN_LEN+1)·WIN_LEN clock edges after the edge that accepts start. The outputs keep their values from then until the next accepted start.
- R7: While a sweep is running, sample writes, chip writes and further start pulses are ignored. The result and its timing depend only on the contents present when the sweep was started.
- R8: A sample write stores ld_sample at address ld_addr. A chip write stores chip_pos at window position chip_idx. Both are captured at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Sample write enable |
| ld_addr | input | ADDR_W | Sample address within the frame |
| ld_sample | input | SAMPLE_W | Signed sample value |
| chip_we | input | 1 | Chip write enable |
| chip_idx | input | CIDX_W | Window position of the chip |
| chip_pos | input | 1 | Chip value, 1 = +1, 0 = -1 |
| start | input | 1 | Starts a sweep when idle |
| done | output | 1 | One-cycle end-of-sweep pulse |
| path0_delay | output | ADDR_W | Offset of strongest path |
| path0_mag | output | ACC_W | Magnitude of strongest path |
| path1_delay | output | ADDR_W | Offset of second path |
| path1_mag | output | ACC_W | Magnitude of second path |
| path2_delay | output | ADDR_W | Offset of third path |
| path2_mag | output | ACC_W | Magnitude of third path |

## Verification
The bench builds the block with a 16-sample window over a 128-sample frame. This gives 113 candidate offsets and 1808 cycles per sweep, so several full sweeps fit in a short run and the exact done latency can be counted. With this size, every offset's sum can be recomputed in the bench. The small sizes also allow planted peaks, full-scale negative windows, ties on an all-zero frame and writes injected mid-sweep. The 13-bit magnitude width is exercised at its extreme by a window of -128 samples.

// File: rtl/path_search_pkg.sv
package path_search_pkg;
   typedef enum logic {PS_IDLE, PS_RUN} ps_state_e;

   function automatic int unsigned acc_width(int unsigned sw, int unsigned win);
      return sw + $clog2(win) + 1;
   endfunction
endpackage

// File: rtl/path_search_store.sv
module path_search_store #(
   parameter int unsigned SAMPLE_W  = 8,
   parameter int unsigned BUF_DEPTH = 5120,
   parameter int unsigned WIN_LEN   = 320,
   localparam int unsigned ADDR_W   = $clog2(BUF_DEPTH),
   localparam int unsigned CIDX_W   = $clog2(WIN_LEN)
) (
   input  logic                       clk,
   input  logic                       s_we,
   input  logic [ADDR_W-1:0]          s_waddr,
   input  logic signed [SAMPLE_W-1:0] s_wdata,
   input  logic                       c_we,
   input  logic [CIDX_W-1:0]          c_widx,
   input  logic                       c_wbit,
   input  logic [ADDR_W-1:0]          s_raddr,
   output logic signed [SAMPLE_W-1:0] s_rdata,
   input  logic [CIDX_W-1:0]          c_ridx,
   output logic                       c_rbit
);
   logic signed [SAMPLE_W-1:0] frame_mem [BUF_DEPTH];
   logic [WIN_LEN-1:0]         chip_mem;

   always_ff @(posedge clk) begin
      if (s_we) frame_mem[s_waddr] <= s_wdata;
   end

   always_ff @(posedge clk) begin
      if (c_we) chip_mem[c_widx] <= c_wbit;
   end

   assign s_rdata = frame_mem[s_raddr];
   assign c_rbit  = chip_mem[c_ridx];
endmodule

// File: rtl/path_search_accum.sv
module path_search_accum #(
   parameter int unsigned SAMPLE_W = 8,
   parameter int unsigned ACC_W    = 18
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       clr,
   input  logic                       en,
   input  logic                       win_end,
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic                       chip_pos,
   output logic [ACC_W-1:0]           win_mag
);
   logic signed [ACC_W-1:0] acc_q;
   logic signed [ACC_W-1:0] s_ext;
   logic signed [ACC_W-1:0] sum_nx;

   assign s_ext  = {{(ACC_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
   assign sum_nx = chip_pos ? (acc_q + s_ext) : (acc_q - s_ext);
   assign win_mag = sum_nx[ACC_W-1] ? ACC_W'(-sum_nx) : ACC_W'(sum_nx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc_q <= '0;
      else if (clr)              acc_q <= '0;
      else if (en && win_end)    acc_q <= '0;
      else if (en)               acc_q <= sum_nx;
   end
endmodule

// File: rtl/path_search_rank.sv
module path_search_rank #(
   parameter int unsigned NPATH = 3,
   parameter int unsigned MAG_W = 18,
   parameter int unsigned OFF_W = 13
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr,
   input  logic                        ins,
   input  logic [MAG_W-1:0]            ins_mag,
   input  logic [OFF_W-1:0]            ins_off,
   output logic [NPATH-1:0][MAG_W-1:0] mag_o,
   output logic [NPATH-1:0][OFF_W-1:0] off_o
);
   logic [NPATH-1:0]            vld_q, vld_n, beats;
   logic [NPATH-1:0][MAG_W-1:0] mag_q, mag_n;
   logic [NPATH-1:0][OFF_W-1:0] off_q, off_n;

   for (genvar i = 0; i < NPATH; i++) begin : g_slot
      assign beats[i] = !vld_q[i] || (ins_mag > mag_q[i]);
      if (i == 0) begin : g_head
         assign vld_n[i] = beats[i] ? 1'b1    : vld_q[i];
         assign mag_n[i] = beats[i] ? ins_mag : mag_q[i];
         assign off_n[i] = beats[i] ? ins_off : off_q[i];
      end else begin : g_tail
         always_comb begin
            if (!beats[i]) begin
               vld_n[i] = vld_q[i];
               mag_n[i] = mag_q[i];
               off_n[i] = off_q[i];
            end else if (beats[i-1]) begin
               vld_n[i] = vld_q[i-1];
               mag_n[i] = mag_q[i-1];
               off_n[i] = off_q[i-1];
            end else begin
               vld_n[i] = 1'b1;
               mag_n[i] = ins_mag;
               off_n[i] = ins_off;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         mag_q <= '0;
         off_q <= '0;
      end else if (clr) begin
         vld_q <= '0;
         mag_q <= '0;
         off_q <= '0;
      end else if (ins) begin
         vld_q <= vld_n;
         mag_q <= mag_n;
         off_q <= off_n;
      end
   end

   assign mag_o = mag_q;
   assign off_o = off_q;
endmodule

// File: rtl/path_search_top.sv
module path_search_top
   import path_search_pkg::*;
#(
   parameter int unsigned SAMPLE_W  = 8,
   parameter int unsigned WIN_LEN   = 320,
   parameter int unsigned BUF_DEPTH = 5120,
   localparam int unsigned ADDR_W   = $clog2(BUF_DEPTH),
   localparam int unsigned CIDX_W   = $clog2(WIN_LEN),
   localparam int unsigned ACC_W    = acc_width(SAMPLE_W, WIN_LEN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ld_we,
   input  logic [ADDR_W-1:0]   ld_addr,
   input  logic [SAMPLE_W-1:0] ld_sample,
   input  logic                chip_we,
   input  logic [CIDX_W-1:0]   chip_idx,
   input  logic                chip_pos,
   input  logic                start,
   output logic                done,
   output logic [ADDR_W-1:0]   path0_delay,
   output logic [ACC_W-1:0]    path0_mag,
   output logic [ADDR_W-1:0]   path1_delay,
   output logic [ACC_W-1:0]    path1_mag,
   output logic [ADDR_W-1:0]   path2_delay,
   output logic [ACC_W-1:0]    path2_mag
);
   localparam int unsigned NPATH    = 3;
   localparam int unsigned LAST_OFF = BUF_DEPTH - WIN_LEN;

   if (WIN_LEN < 2) begin : g_bad_win
      $error("WIN_LEN must be at least 2");
   end
   if (BUF_DEPTH < WIN_LEN + NPATH - 1) begin : g_bad_buf
      $error("BUF_DEPTH too small for three candidate offsets");
   end
   if (SAMPLE_W < 2) begin : g_bad_sw
      $error("SAMPLE_W must be at least 2");
   end

   ps_state_e           state_q;
   logic [ADDR_W-1:0]   off_q;
   logic [CIDX_W-1:0]   k_q;
   logic                done_q;
   logic                busy;
   logic                go;
   logic                win_end;
   logic                sweep_end;
   logic signed [SAMPLE_W-1:0] rd_sample;
   logic                rd_chip;
   logic [ACC_W-1:0]    win_mag;
   logic [NPATH-1:0][ACC_W-1:0]  rk_mag;
   logic [NPATH-1:0][ADDR_W-1:0] rk_off;

   assign busy      = (state_q == PS_RUN);
   assign go        = start && !busy;
   assign win_end   = (k_q == CIDX_W'(WIN_LEN - 1));
   assign sweep_end = win_end && (off_q == ADDR_W'(LAST_OFF));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         off_q   <= '0;
         k_q     <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            state_q <= PS_RUN;
            off_q   <= '0;
            k_q     <= '0;
         end else if (busy) begin
            if (win_end) begin
               k_q   <= '0;
               off_q <= off_q + 1'b1;
               if (sweep_end) begin
                  state_q <= PS_IDLE;
                  done_q  <= 1'b1;
               end
            end else begin
               k_q <= k_q + 1'b1;
            end
         end
      end
   end

   path_search_store #(
      .SAMPLE_W(SAMPLE_W), .BUF_DEPTH(BUF_DEPTH), .WIN_LEN(WIN_LEN)
   ) store_i (
      .clk(clk),
      .s_we(ld_we && !busy), .s_waddr(ld_addr), .s_wdata(ld_sample),
      .c_we(chip_we && !busy), .c_widx(chip_idx), .c_wbit(chip_pos),
      .s_raddr(off_q + ADDR_W'(k_q)), .s_rdata(rd_sample),
      .c_ridx(k_q), .c_rbit(rd_chip)
   );

   path_search_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) accum_i (
      .clk(clk), .rst_n(rst_n), .clr(go), .en(busy), .win_end(win_end),
      .sample(rd_sample), .chip_pos(rd_chip), .win_mag(win_mag)
   );

   path_search_rank #(.NPATH(NPATH), .MAG_W(ACC_W), .OFF_W(ADDR_W)) rank_i (
      .clk(clk), .rst_n(rst_n), .clr(go), .ins(busy && win_end),
      .ins_mag(win_mag), .ins_off(off_q), .mag_o(rk_mag), .off_o(rk_off)
   );

   assign done        = done_q;
   assign path0_delay = rk_off[0];
   assign path0_mag   = rk_mag[0];
   assign path1_delay = rk_off[1];
   assign path1_mag   = rk_mag[1];
   assign path2_delay = rk_off[2];
   assign path2_mag   = rk_mag[2];
endmodule

// File: rtl/path_search_chk.sv
module path_search_chk #(
   parameter int unsigned OFF_W    = 13,
   parameter int unsigned MAG_W    = 18,
   parameter int unsigned LAST_OFF = 4800
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [OFF_W-1:0] d0,
   input logic [OFF_W-1:0] d1,
   input logic [OFF_W-1:0] d2,
   input logic [MAG_W-1:0] m0,
   input logic [MAG_W-1:0] m1,
   input logic [MAG_W-1:0] m2
);
   a_r4_sorted: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (m0 >= m1) && (m1 >= m2));

   a_r5_tie_order: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((m0 != m1) || (d0 < d1)) && ((m1 != m2) || (d1 < d2)));

   a_r2_delay_range: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (d0 <= OFF_W'(LAST_OFF)) && (d1 <= OFF_W'(LAST_OFF))
               && (d2 <= OFF_W'(LAST_OFF)));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable({d0, d1, d2, m0, m1, m2}));

   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));
endmodule

bind path_search_top path_search_chk #(
   .OFF_W(ADDR_W), .MAG_W(ACC_W), .LAST_OFF(BUF_DEPTH - WIN_LEN)
) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .d0(path0_delay), .d1(path1_delay), .d2(path2_delay),
   .m0(path0_mag), .m1(path1_mag), .m2(path2_mag)
);

// File: tb/path_search_top_tb_top.sv
module path_search_top_tb_top;
   localparam int SW    = 8;
   localparam int WIN   = 16;
   localparam int BUF   = 128;
   localparam int AW    = $clog2(BUF);
   localparam int CW    = $clog2(WIN);
   localparam int MW    = SW + $clog2(WIN) + 1;
   localparam int NOFF  = BUF - WIN + 1;
   localparam int SWEEP = NOFF * WIN;
   localparam int CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_we = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [SW-1:0] ld_sample = '0;
   logic          chip_we = 1'b0;
   logic [CW-1:0] chip_idx = '0;
   logic          chip_pos = 1'b0;
   logic          start = 1'b0;
   logic          done;
   logic [AW-1:0] d0, d1, d2;
   logic [MW-1:0] m0, m1, m2;

   int checks = 0;
   int errors = 0;
   int smp [BUF];
   bit chp [WIN];
   int exp_d [3];
   int exp_m [3];
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   path_search_top #(.SAMPLE_W(SW), .WIN_LEN(WIN), .BUF_DEPTH(BUF)) dut_i (
      .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
      .ld_sample(ld_sample), .chip_we(chip_we), .chip_idx(chip_idx),
      .chip_pos(chip_pos), .start(start), .done(done),
      .path0_delay(d0), .path0_mag(m0), .path1_delay(d1), .path1_mag(m1),
      .path2_delay(d2), .path2_mag(m2)
   );

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int next_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return int'(lfsr);
   endfunction

   // reference: R2 correlation, R3 magnitude, R4/R5 ranking
   task automatic compute_expected();
      for (int s = 0; s < 3; s++) begin exp_d[s] = -1; exp_m[s] = -1; end
      for (int o = 0; o < NOFF; o++) begin
         int acc = 0;
         for (int k = 0; k < WIN; k++) acc += chp[k] ? smp[o+k] : -smp[o+k];
         if (acc < 0) acc = -acc;
         for (int s = 0; s < 3; s++) begin
            if (acc > exp_m[s]) begin
               for (int t = 2; t > s; t--) begin
                  exp_m[t] = exp_m[t-1]; exp_d[t] = exp_d[t-1];
               end
               exp_m[s] = acc; exp_d[s] = o;
               break;
            end
         end
      end
   endtask

   task automatic load_all();   // R8
      for (int i = 0; i < BUF; i++) begin
         @(negedge clk);
         ld_we = 1'b1; ld_addr = AW'(i); ld_sample = SW'(smp[i]);
      end
      for (int k = 0; k < WIN; k++) begin
         @(negedge clk);
         ld_we = 1'b0; chip_we = 1'b1; chip_idx = CW'(k); chip_pos = chp[k];
      end
      @(negedge clk);
      ld_we = 1'b0; chip_we = 1'b0;
   endtask

   task automatic run_and_check(input string tag, input bit meddle);
      int cyc = 0;
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
      while (!done && cyc < SWEEP + 10) begin
         @(posedge clk);
         #1 cyc++;
         if (meddle && cyc == 200) begin
            ld_we = 1'b1; ld_addr = AW'(40); ld_sample = 8'h7F;
            chip_we = 1'b1; chip_idx = '0; chip_pos = ~chp[0];
            start = 1'b1;
         end
         if (meddle && cyc == 201) begin
            ld_we = 1'b0; chip_we = 1'b0; start = 1'b0;
         end
      end
      check({tag, " R6 latency"}, cyc, SWEEP);
      compute_expected();
      check({tag, " R2/R4 d0"}, int'(d0), exp_d[0]);
      check({tag, " R3/R4 m0"}, int'(m0), exp_m[0]);
      check({tag, " R2/R4 d1"}, int'(d1), exp_d[1]);
      check({tag, " R3/R4 m1"}, int'(m1), exp_m[1]);
      check({tag, " R5 d2"}, int'(d2), exp_d[2]);
      check({tag, " R3 m2"}, int'(m2), exp_m[2]);
      @(posedge clk);
      #1 check({tag, " R6 done pulse"}, int'(done), 0);
      repeat (5) @(posedge clk);
      #1 check({tag, " R6 hold"}, int'(m0), exp_m[0]);
   endtask

   task automatic t_reset();    // R1
      check("R1 done", int'(done), 0);
      check("R1 d0", int'(d0), 0);
      check("R1 m0", int'(m0), 0);
      check("R1 m2", int'(m2), 0);
   endtask

   task automatic t_planted();  // R2 R3 R4
      for (int k = 0; k < WIN; k++) chp[k] = next_rand() [0];
      for (int i = 0; i < BUF; i++) smp[i] = 0;
      for (int k = 0; k < WIN; k++) begin
         smp[5+k]  += chp[k] ? 10 : -10;
         smp[37+k] += chp[k] ? 20 : -20;
         smp[90+k] += chp[k] ? -30 : 30;
      end
      load_all();
      run_and_check("planted", 1'b0);
      check("R4 strongest is negative peak", int'(d0), 90);
   endtask

   task automatic t_noise();    // R2 R3 full scale
      for (int i = 0; i < BUF; i++) smp[i] = (next_rand() % 256) - 128;
      for (int k = 0; k < WIN; k++) begin
         chp[k] = 1'b1; smp[60+k] = -128;
      end
      load_all();
      run_and_check("fullscale", 1'b0);
      check("R3 extreme magnitude", int'(m0), 128 * WIN);
   endtask

   task automatic t_ties();     // R5
      for (int i = 0; i < BUF; i++) smp[i] = 0;
      load_all();
      run_and_check("zeros", 1'b0);
      check("R5 zero d0", int'(d0), 0);
      check("R5 zero d1", int'(d1), 1);
      for (int k = 0; k < WIN; k++) begin
         smp[70+k] = chp[k] ? 9 : -9;
         smp[20+k] = chp[k] ? -9 : 9;
      end
      load_all();
      run_and_check("ties", 1'b0);
      check("R5 earlier wins tie", int'(d0), 20);
   endtask

   task automatic t_busy();     // R7
      for (int i = 0; i < BUF; i++) smp[i] = (next_rand() % 64) - 32;
      load_all();
      run_and_check("busy R7", 1'b1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk) rst_n = 1'b1;
      t_planted();
      t_noise();
      t_ties();
      t_busy();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule